// File: doc/BRIEF.md
# Configuration Bitstream Download Engine

This block takes a device configuration bitstream from a host as a series of 16-bit words and passes it to the configuration port of a target device. The port is either byte-wide or serial, selected by a parameter. The host writes words and reads status through one shared register location: a write delivers a word and a read returns the status word. A program pulse, driven from a general-purpose output of the bus bridge, restarts the engine. After a fixed delay the engine raises its ready indication and waits for words.

Flow control works one word at a time. The host polls a transmit-ready flag before every write. A fixed signature in the top nibble of the status word tells the host that this engine has flow control. After every word the host checks that the ready indication is still high. When the last word has gone out, the host watches the target's completion signal, which the engine returns as a status bit.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset, status reads 0x5000. Status bit 1 (ready), bit 2 (transmit-ready), bit 3 (error) and bit 0 (done) are all low, and `cfg_strobe_o` is low.
- R2: Status bit 1 rises exactly INIT_DLY+1 clock edges after the last edge at which `prog_i` is sampled high, or after reset is released. It stays high until the next program pulse.
- R3: Status bits 15:12 always hold the signature value VERSION, default 0x5.
- R4: When a write is accepted, status bit 2 is low from the next edge onward. It returns high on the edge that emits the word's final beat.
- R5: An accepted word leaves as 16/BUS_W beats, one per clock, starting the edge after the write. Bits 15:8 go out first, then bits 7:0; with BUS_W=1 the order is bit 15 down to bit 0. Each beat is marked by `cfg_strobe_o` high.
- R6: A write made while status bit 2 is low is ignored and does not change the outgoing beats. It sets status bit 3, which stays set until the next program pulse.
- R7: A program pulse discards any partially sent word, stops the strobe on the next edge, and clears status bit 3.
- R8: Status bit 0 follows `done_i` after SYNC_STAGES clock edges.
- R9: Status bit 1 stays high across any number of accepted words, including back-to-back writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_i | input | 1 | Program pulse (restart), active high |
| wr_en_i | input | 1 | Host write strobe for the shared register |
| wr_data_i | input | 16 | Host write word |
| status_o | output | 16 | Status word returned on host reads |
| done_i | input | 1 | Target completion signal, asynchronous |
| cfg_data_o | output | BUS_W | Configuration beat to the target |
| cfg_strobe_o | output | 1 | Marks a valid beat on `cfg_data_o` |

## Verification
Embedded properties check, on every cycle, the rules that span one or two clocks. An accepted write drops transmit-ready at once. A refused write sets the error flag. A program pulse clears the ready bit and the strobe on the next edge. A load reaches the serializer only when it is idle. Properties also check that ready never falls except after a program pulse. The testbench scenarios show the byte order and beat values of random words, and the exact length of the ready delay. They also show that a refused write leaves the stream unchanged, that an aborted word is dropped, and the latency of the done synchronizer.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
    localparam int WORD_W = 16;
    // status bit positions decoded by host software
    localparam int ST_DONE = 0;
    localparam int ST_RDY  = 1;
    localparam int ST_TXR  = 2;
    localparam int ST_ERR  = 3;
    localparam int ST_SIG  = 12;
endpackage

// File: rtl/cfgl_init_seq.sv
module cfgl_init_seq #(
    parameter int INIT_DLY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_i,
    output logic init_o
);
    localparam int CNT_W = $clog2(INIT_DLY + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             init;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (prog_i) begin
            seq_d.cnt  = CNT_W'(INIT_DLY);
            seq_d.init = 1'b0;
        end else if (seq_q.cnt != '0) begin
            seq_d.cnt = seq_q.cnt - CNT_W'(1);
        end else begin
            seq_d.init = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.cnt  <= CNT_W'(INIT_DLY);
            seq_q.init <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign init_o = seq_q.init;

    // R2: ready only falls as a result of a program pulse
    assert_init_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q.init) |-> $past(prog_i));
endmodule

// File: rtl/cfgl_serializer.sv
module cfgl_serializer
    import cfgl_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic             idle_o,
    output logic [BUS_W-1:0] data_o,
    output logic             strobe_o
);
    localparam int BEATS = WORD_W / BUS_W;
    localparam int CW    = $clog2(BEATS + 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CW-1:0]     left;
        logic [BUS_W-1:0]  dat;
        logic              stb;
    } ser_t;

    ser_t ser_d, ser_q;

    always_comb begin
        ser_d     = ser_q;
        ser_d.stb = 1'b0;
        if (clear_i) begin
            ser_d.sh   = '0;
            ser_d.left = '0;
        end else if (load_i) begin
            ser_d.sh   = word_i;
            ser_d.left = CW'(BEATS);
        end else if (ser_q.left != '0) begin
            ser_d.dat  = ser_q.sh[WORD_W-1 -: BUS_W];
            ser_d.stb  = 1'b1;
            ser_d.sh   = ser_q.sh << BUS_W;
            ser_d.left = ser_q.left - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_q <= '0;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign idle_o   = (ser_q.left == '0);
    assign data_o   = ser_q.dat;
    assign strobe_o = ser_q.stb;

    // R6: the word being shifted is never overwritten by a new load
    assert_load_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> idle_o);
endmodule

// File: rtl/cfgl_status.sv
module cfgl_status #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_i,
    input  logic bad_wr_i,
    input  logic done_i,
    output logic err_o,
    output logic done_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   err;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (SYNC_STAGES > 1)
            st_d.sync = {st_q.sync[SYNC_STAGES-2:0], done_i};
        else
            st_d.sync[0] = done_i;
        if (prog_i)
            st_d.err = 1'b0;
        else if (bad_wr_i)
            st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o  = st_q.err;
    assign done_o = st_q.sync[SYNC_STAGES-1];

    // R6: a refused write always leaves the sticky flag set
    assert_err_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr_i && !prog_i |=> err_o);
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
    import cfgl_pkg::*;
#(
    parameter int         BUS_W       = 8,
    parameter int         INIT_DLY    = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] VERSION     = 4'h5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_i,
    input  logic             wr_en_i,
    input  logic [15:0]      wr_data_i,
    output logic [15:0]      status_o,
    input  logic             done_i,
    output logic [BUS_W-1:0] cfg_data_o,
    output logic             cfg_strobe_o
);
    logic init_w, idle_w, txready_w, accept_w, bad_w, err_w, done_w;

    assign txready_w = init_w && idle_w;
    assign accept_w  = wr_en_i && txready_w && !prog_i;
    assign bad_w     = wr_en_i && !txready_w && !prog_i;

    cfgl_init_seq #(.INIT_DLY(INIT_DLY)) u_init (
        .clk(clk), .rst_n(rst_n), .prog_i(prog_i), .init_o(init_w)
    );

    cfgl_serializer #(.BUS_W(BUS_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .clear_i(prog_i), .load_i(accept_w),
        .word_i(wr_data_i), .idle_o(idle_w), .data_o(cfg_data_o),
        .strobe_o(cfg_strobe_o)
    );

    cfgl_status #(.SYNC_STAGES(SYNC_STAGES)) u_st (
        .clk(clk), .rst_n(rst_n), .prog_i(prog_i), .bad_wr_i(bad_w),
        .done_i(done_i), .err_o(err_w), .done_o(done_w)
    );

    always_comb begin
        status_o                     = '0;
        status_o[ST_SIG +: 4]        = VERSION;
        status_o[ST_ERR]             = err_w;
        status_o[ST_TXR]             = txready_w;
        status_o[ST_RDY]             = init_w;
        status_o[ST_DONE]            = done_w;
    end

    // R4: an accepted word blocks the next one immediately
    assert_txready_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_w |=> !status_o[ST_TXR]);

    // R7: a program pulse stops the stream and clears ready
    assert_prog_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_i |=> !cfg_strobe_o && !status_o[ST_RDY] && !status_o[ST_ERR]);
endmodule

// File: tb/cfg_stream_loader_tb.sv
module cfg_stream_loader_tb;
    localparam int BUS_W    = 8;
    localparam int INIT_DLY = 8;
    localparam int BEATS    = 16 / BUS_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog = 1'b0;
    logic wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic done = 1'b0;
    logic [15:0] status;
    logic [BUS_W-1:0] cfg_data;
    logic cfg_strobe;

    int n_chk = 0;
    int n_bad = 0;

    cfg_stream_loader #(.BUS_W(BUS_W), .INIT_DLY(INIT_DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .prog_i(prog), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .status_o(status), .done_i(done),
        .cfg_data_o(cfg_data), .cfg_strobe_o(cfg_strobe)
    );

    always #5 clk = ~clk;

    function automatic logic [BUS_W-1:0] beat_of(logic [15:0] w, int b);
        return BUS_W'(w >> (16 - BUS_W * (b + 1)));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_prog();
        prog = 1'b1;
        step();
        prog = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 100 && !status[2]; i++) step();
    endtask

    // write one word and check every beat
    task automatic send_word(logic [15:0] w);
        wait_ready();
        wr_en = 1'b1;
        wr_data = w;
        step();
        wr_en = 1'b0;
        chk("R4 txready low", 32'(status[2]), 32'h0);
        for (int b = 0; b < BEATS; b++) begin
            step();
            chk("R5 strobe", 32'(cfg_strobe), 32'h1);
            chk("R5 beat", 32'(cfg_data), 32'(beat_of(w, b)));
        end
        chk("R4 txready back", 32'(status[2]), 32'h1);
        chk("R9 ready held", 32'(status[1]), 32'h1);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));
        step();
        chk("R1 reset status", 32'(status), 32'h5000);
        chk("R1 reset strobe", 32'(cfg_strobe), 32'h0);
        rst_n = 1'b1;
        step();
        // R2 delay after reset release
        for (int n = 1; n <= INIT_DLY + 1; n++) begin
            chk("R2 ready after reset", 32'(status[1]), 32'(n == INIT_DLY + 1));
            if (n <= INIT_DLY) step();
        end
        // R2 delay after a program pulse
        prog = 1'b1;
        step();
        prog = 1'b0;
        for (int n = 1; n <= INIT_DLY + 1; n++) begin
            step();
            chk("R2 ready after prog", 32'(status[1]), 32'(n == INIT_DLY + 1));
        end
        chk("R3 signature", 32'(status[15:12]), 32'h5);
        // stream header then random words back to back
        send_word(16'hFF20);
        send_word(16'h0000);
        send_word(16'hFFFF);
        for (int k = 0; k < 40; k++) send_word(16'($urandom));
        chk("R6 no error yet", 32'(status[3]), 32'h0);
        // refused write during serialization
        wr_en = 1'b1;
        wr_data = 16'hA55A;
        step();
        wr_data = 16'h1234;
        step();
        wr_en = 1'b0;
        chk("R6 first beat kept", 32'(cfg_data), 32'(beat_of(16'hA55A, 0)));
        step();
        chk("R6 second beat kept", 32'(cfg_data), 32'(beat_of(16'hA55A, 1)));
        chk("R6 error sticky", 32'(status[3]), 32'h1);
        step();
        chk("R6 nothing extra", 32'(cfg_strobe), 32'h0);
        send_word(16'h0F0F);
        chk("R6 error still set", 32'(status[3]), 32'h1);
        // abort mid word
        wait_ready();
        wr_en = 1'b1;
        wr_data = 16'hBEEF;
        step();
        wr_en = 1'b0;
        prog = 1'b1;
        step();
        prog = 1'b0;
        chk("R7 strobe stopped", 32'(cfg_strobe), 32'h0);
        chk("R7 error cleared", 32'(status[3]), 32'h0);
        chk("R7 ready low", 32'(status[1]), 32'h0);
        for (int n = 0; n < INIT_DLY + 3; n++) begin
            step();
            if (cfg_strobe) chk("R7 partial dropped", 32'(cfg_strobe), 32'h0);
        end
        // write while not ready sets error
        pulse_prog();
        wr_en = 1'b1;
        wr_data = 16'h7777;
        step();
        wr_en = 1'b0;
        chk("R6 write before ready", 32'(status[3]), 32'h1);
        chk("R6 no beat", 32'(cfg_strobe), 32'h0);
        pulse_prog();
        wait_ready();
        send_word(16'h8001);
        // done synchronizer
        done = 1'b1;
        step();
        chk("R8 done not yet", 32'(status[0]), 32'h0);
        step();
        chk("R8 done seen", 32'(status[0]), 32'h1);
        done = 1'b0;
        step();
        step();
        chk("R8 done released", 32'(status[0]), 32'h0);
        chk("R3 signature end", 32'(status[15:12]), 32'h5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule